// File: doc/BRIEF.md
# Load/Store Address and Sequencing Unit

This unit carries out the data-movement instructions of a 16-bit processor against a word-addressed 16-bit memory with a one-cycle read latency. When it is idle and sees a start strobe, it takes the instruction word, the already-incremented program counter, a base register value and a store-data value. It works out the effective address and then runs the memory accesses the instruction needs. A direct load needs one read. A store needs one write. An indirect access needs a pointer read, followed by the final read or write. Address generation alone needs no memory access.

On completion the unit pulses `done_o`. For loads and address generation it also presents the destination register index and the value to write back, with a write-enable. While a memory sequence is in progress `busy_o` is high and new start strobes are dropped. Register file access, instruction fetch and condition codes are handled elsewhere in the pipeline.

Top module: `lsu_seq`

## Requirements
- R1: A start is accepted only while the unit is idle. Bits [15:12] select the operation: 0010 direct PC-relative load, 0110 base+offset load, 1010 indirect load, 1110 address generation, 0011 direct PC-relative store, 0111 base+offset store, 1011 indirect store. Any other code is ignored: there is no memory request, no done and no busy.
- R2: PC-relative addressing uses pc_i (the PC already incremented) plus bits [8:0] sign-extended to 16 bits, wrapping modulo 2^16.
- R3: Base+offset addressing uses base_i plus bits [5:0] sign-extended to 16 bits.
- R4: Address generation issues no memory request. It raises done_o and rf_we_o, with rf_wdata_o equal to the PC-relative address, in the clock cycle right after the start edge.
- R5: A direct store issues one write (mem_req_o=1, mem_we_o=1, mem_wdata_o=src_i) in the cycle after the start edge and raises done_o one cycle later. rf_we_o stays 0.
- R6: A direct load issues one read in the cycle after the start edge. Data returns one cycle after the request. done_o, rf_we_o and rf_wdata_o equal to the returned word appear 2 cycles after the start edge.
- R7: An indirect access first reads the word at the effective address and uses that word as the address of a second access (a read for loads, a write of src_i for stores). The indirect load completes 4 cycles after the start edge and the indirect store 3 cycles after it.
- R8: rf_we_o is high only together with done_o, and rf_waddr_o equals bits [11:9] of the instruction.
- R9: busy_o is high from the cycle after an accepted memory start until its done cycle, and is low in the done cycle. A start while busy is ignored.
- R10: While rst_ni is low, busy_o, done_o, rf_we_o and mem_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 16 | Incremented program counter |
| base_i | input | 16 | Base register value |
| src_i | input | 16 | Store data (source register value) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid one cycle after a read request |
| busy_o | output | 1 | Memory sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rf_we_o | output | 1 | Destination register write enable |
| rf_waddr_o | output | 3 | Destination register index |
| rf_wdata_o | output | 16 | Write-back value |

## Verification
If the sequencer state is wrong, the done pulse comes at the wrong cycle distance from the start edge, or a read request is followed at once by done. Either shows at the ports within one to four cycles. If the indirect phase flag is wrong, the memory model sees the wrong number of requests, or the final access is made at the pointer location and not at the address the pointer holds. A misdecoded instruction class shows as a store that raises the register write-enable, or as an address generation that touches memory, both in the done cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned RIDX_W   = 3;
  localparam int unsigned OPC_W    = 4;
  localparam int unsigned PCOFF_W  = 9;
  localparam int unsigned BOFF_W   = 6;
  localparam int unsigned OPC_LSB  = WORD_W - OPC_W;
  localparam int unsigned RIDX_LSB = OPC_LSB - RIDX_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_LD_PC  = 4'b0010,
    OPC_LD_B   = 4'b0110,
    OPC_LD_IND = 4'b1010,
    OPC_AGEN   = 4'b1110,
    OPC_ST_PC  = 4'b0011,
    OPC_ST_B   = 4'b0111,
    OPC_ST_IND = 4'b1011
  } opc_e;

  typedef struct packed {
    logic valid;
    logic agen;
    logic store;
    logic indirect;
    logic use_base;
  } dec_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACC  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] base_i,
  output dec_t              dec_o,
  output logic [ADDR_W-1:0] ea_o
);
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] pc_off, base_off;

  assign opc = instr_i[WORD_W-1:OPC_LSB];

  assign pc_off   = {{(ADDR_W-PCOFF_W){instr_i[PCOFF_W-1]}}, instr_i[PCOFF_W-1:0]};
  assign base_off = {{(ADDR_W-BOFF_W){instr_i[BOFF_W-1]}}, instr_i[BOFF_W-1:0]};

  always_comb begin
    dec_o = '0;
    unique case (opc)
      OPC_LD_PC:  dec_o.valid = 1'b1;
      OPC_LD_B:   begin dec_o.valid = 1'b1; dec_o.use_base = 1'b1; end
      OPC_LD_IND: begin dec_o.valid = 1'b1; dec_o.indirect = 1'b1; end
      OPC_AGEN:   begin dec_o.valid = 1'b1; dec_o.agen = 1'b1; end
      OPC_ST_PC:  begin dec_o.valid = 1'b1; dec_o.store = 1'b1; end
      OPC_ST_B:   begin dec_o.valid = 1'b1; dec_o.store = 1'b1; dec_o.use_base = 1'b1; end
      OPC_ST_IND: begin dec_o.valid = 1'b1; dec_o.store = 1'b1; dec_o.indirect = 1'b1; end
      default:    dec_o = '0;
    endcase
  end

  assign ea_o = dec_o.use_base ? (base_i + base_off) : (pc_i + pc_off);
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_mem_i,    // accepted start needing memory
  input  logic ind_i,       // accepted start is indirect
  input  logic store_i,     // latched: current op is a store
  output logic idle_o,
  output logic acc_o,       // memory request cycle
  output logic final_o,     // access is the final one of the sequence
  output logic ptr_load_o,  // capture pointer word as next address
  output logic fin_o        // sequence completes at next edge
);
  sq_state_e state_q, state_d;
  logic      ind_pend_q, ind_pend_d;

  assign idle_o     = (state_q == SQ_IDLE);
  assign acc_o      = (state_q == SQ_ACC);
  assign final_o    = !ind_pend_q;
  assign ptr_load_o = (state_q == SQ_WAIT) && ind_pend_q;
  assign fin_o      = ((state_q == SQ_ACC) && store_i && !ind_pend_q) ||
                      ((state_q == SQ_WAIT) && !ind_pend_q);

  always_comb begin
    state_d    = state_q;
    ind_pend_d = ind_pend_q;
    unique case (state_q)
      SQ_IDLE: if (go_mem_i) begin
        state_d    = SQ_ACC;
        ind_pend_d = ind_i;
      end
      SQ_ACC: state_d = (store_i && !ind_pend_q) ? SQ_IDLE : SQ_WAIT;
      SQ_WAIT: begin
        if (ind_pend_q) begin
          state_d    = SQ_ACC;
          ind_pend_d = 1'b0;
        end else begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SQ_IDLE;
      ind_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ind_pend_q <= ind_pend_d;
    end
  end
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] src_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [WORD_W-1:0] rf_wdata_o
);
  dec_t              dec;
  logic [ADDR_W-1:0] ea;
  logic              idle, acc, final_acc, ptr_load, fin;
  logic              accept, agen_go, mem_go;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] sdata_q;
  logic              store_q;
  logic [RIDX_W-1:0] waddr_q;
  logic              done_q, rf_we_q;
  logic [WORD_W-1:0] wdata_q;

  lsu_decode u_dec (
    .instr_i (instr_i),
    .pc_i    (pc_i),
    .base_i  (base_i),
    .dec_o   (dec),
    .ea_o    (ea)
  );

  assign accept  = start_i && idle && dec.valid;
  assign agen_go = accept && dec.agen;
  assign mem_go  = accept && !dec.agen;

  lsu_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_mem_i   (mem_go),
    .ind_i      (dec.indirect),
    .store_i    (store_q),
    .idle_o     (idle),
    .acc_o      (acc),
    .final_o    (final_acc),
    .ptr_load_o (ptr_load),
    .fin_o      (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      sdata_q <= '0;
      store_q <= 1'b0;
      waddr_q <= '0;
    end else if (accept) begin
      addr_q  <= ea;
      sdata_q <= src_i;
      store_q <= dec.store;
      waddr_q <= instr_i[RIDX_LSB +: RIDX_W];
    end else if (ptr_load) begin
      addr_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rf_we_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      done_q  <= agen_go || fin;
      rf_we_q <= agen_go || (fin && !store_q);
      if (agen_go)              wdata_q <= ea;
      else if (fin && !store_q) wdata_q <= mem_rdata_i;
    end
  end

  assign mem_req_o   = acc;
  assign mem_we_o    = acc && store_q && final_acc;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sdata_q;
  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign rf_we_o     = rf_we_q;
  assign rf_waddr_o  = waddr_q;
  assign rf_wdata_o  = wdata_q;
endmodule

// File: rtl/lsu_seq_chk.sv
module lsu_seq_chk
  import lsu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WORD_W-1:0] instr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              rf_we_o
);
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);  // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R9
  AST_WRITE_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |=> (done_o && !rf_we_o));  // R5
  AST_READ_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |=> (busy_o && !done_o));  // R6
  AST_RF_WE_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);  // R8
  AST_BAD_OPC_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (instr_i[15:12] == 4'b0001)) |=> !busy_o && !done_o);  // R1
endmodule

bind lsu_seq lsu_seq_chk chk_i (.*);

// File: tb/lsu_seq_tb_top.sv
`timescale 1ns/1ps
module lsu_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0, pc_i = '0, base_i = '0, src_i = '0;
  logic        mem_req_o, mem_we_o, busy_o, done_o, rf_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, rf_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic [2:0]  rf_waddr_o;

  int checks = 0, errors = 0, req_cnt = 0;
  logic [15:0] mem [0:1023];

  always #2 clk_i = ~clk_i;

  lsu_seq dut_i (.*);

  // memory model: one-cycle read latency, low 10 address bits
  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[9:0]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[9:0]];
      req_cnt <= req_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [15:0] ins, input logic [15:0] pc,
                        input logic [15:0] base, input logic [15:0] src, input int exp_lat,
                        input logic exp_we, input logic [2:0] exp_wa, input logic [15:0] exp_wd,
                        input int exp_reqs);
    int r0, lat;
    @(negedge clk_i);
    r0 = req_cnt;
    start_i = 1'b1; instr_i = ins; pc_i = pc; base_i = base; src_i = src;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    check(lat == exp_lat, {tag, " latency"}, 16'(lat), 16'(exp_lat));
    check(rf_we_o == exp_we, {tag, " R8 rf_we"}, 16'(rf_we_o), 16'(exp_we));
    if (exp_we) begin
      check(rf_waddr_o == exp_wa, {tag, " R8 waddr"}, 16'(rf_waddr_o), 16'(exp_wa));
      check(rf_wdata_o == exp_wd, {tag, " wdata"}, rf_wdata_o, exp_wd);
    end
    check(req_cnt - r0 == exp_reqs, {tag, " request count"}, 16'(req_cnt - r0), 16'(exp_reqs));
  endtask

  task automatic test_reset();
    check(!busy_o && !done_o && !rf_we_o && !mem_req_o, "R10 reset outputs",
          {12'h0, busy_o, done_o, rf_we_o, mem_req_o}, 16'h0);
  endtask

  task automatic test_bad_opcode();
    int r0;
    bit bad;
    @(negedge clk_i);
    r0 = req_cnt;
    start_i = 1'b1; instr_i = 16'h1000; pc_i = 16'h3000;
    @(negedge clk_i);
    start_i = 1'b0;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      if (done_o || busy_o) bad = 1;
      @(negedge clk_i);
    end
    check(!bad, "R1 unknown opcode gives no done/busy", 16'(bad), 16'h0);
    check(req_cnt == r0, "R1 unknown opcode gives no request", 16'(req_cnt - r0), 16'h0);
  endtask

  task automatic test_busy_ignore();
    int dones;
    logic [15:0] got;
    @(negedge clk_i);
    start_i = 1'b1; instr_i = 16'hA7FA; pc_i = 16'h3011;
    @(negedge clk_i);
    instr_i = 16'hEC04; pc_i = 16'h3008;  // address generation while busy
    dones = 0; got = '0;
    for (int k = 0; k < 8; k++) begin
      if (k == 2) start_i = 1'b0;
      if (done_o) begin dones++; got = rf_wdata_o; end
      @(negedge clk_i);
    end
    check(dones == 1, "R9 one done while start held busy", 16'(dones), 16'h1);
    check(got == 16'h5A5A, "R9 busy start ignored, indirect result", got, 16'h5A5A);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    mem[10'h00A] = 16'h1234;
    mem[10'h00F] = 16'hBEEF;
    mem[10'h01F] = 16'h7777;
    mem[10'h00B] = 16'h3020;
    mem[10'h020] = 16'h5A5A;
    mem[10'h005] = 16'h3030;
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    // R4 R2 address generation
    run_op("R4 R2 agen +4", 16'hEC04, 16'h3008, 16'h0, 16'h0, 0, 1'b1, 3'd6, 16'h300C, 0);
    run_op("R4 R2 agen -256 wrap", 16'hE100, 16'h0010, 16'h0, 16'h0, 0, 1'b1, 3'd0, 16'hFF10, 0);
    // R6 R2 direct PC-relative load
    run_op("R6 R2 load pc-rel", 16'h25FC, 16'h300E, 16'h0, 16'h0, 2, 1'b1, 3'd2, 16'h1234, 1);
    // R3 base+offset loads
    run_op("R3 load base -2", 16'h67BE, 16'h0, 16'h3011, 16'h0, 2, 1'b1, 3'd3, 16'hBEEF, 1);
    run_op("R3 load base +31", 16'h621F, 16'h0, 16'h3000, 16'h0, 2, 1'b1, 3'd1, 16'h7777, 1);
    // R5 stores
    run_op("R5 store pc-rel", 16'h3202, 16'h3007, 16'h0, 16'h0005, 1, 1'b0, 3'd0, 16'h0, 1);
    @(negedge clk_i);
    check(mem[10'h009] == 16'h0005, "R5 store pc-rel data", mem[10'h009], 16'h0005);
    run_op("R5 R3 store base", 16'h75BE, 16'h0, 16'h3013, 16'h00AA, 1, 1'b0, 3'd0, 16'h0, 1);
    @(negedge clk_i);
    check(mem[10'h011] == 16'h00AA, "R5 R3 store base data", mem[10'h011], 16'h00AA);
    // R7 indirect
    run_op("R7 load indirect", 16'hA7FA, 16'h3011, 16'h0, 16'h0, 4, 1'b1, 3'd3, 16'h5A5A, 2);
    run_op("R7 store indirect", 16'hB805, 16'h3000, 16'h0, 16'hC0DE, 3, 1'b0, 3'd0, 16'h0, 2);
    @(negedge clk_i);
    check(mem[10'h030] == 16'hC0DE, "R7 store indirect target", mem[10'h030], 16'hC0DE);
    check(mem[10'h005] == 16'h3030, "R7 pointer word untouched", mem[10'h005], 16'h3030);
    test_bad_opcode();
    test_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule